// File: doc/BRIEF.md
# Masked CAN Mailbox Store

This block sits behind a CAN receive engine and in front of a command decoder that serves a bus master. Each incoming frame (an 11-bit identifier and 64 bits of payload) is offered on a valid/ready input. It is compared against sixteen mailbox filters. Each filter is armed by a configuration write and holds an identifier, an optional bit mask and a size threshold. The frame lands in the lowest-numbered mailbox whose filter accepts it. If no filter accepts it, the frame is discarded.

Every mailbox is a small first-in first-out store of frames with its own fill count. When a stored frame lifts the count above the threshold configured for that mailbox, the mailbox's bit in a 16-bit full-status vector is set. A level interrupt is driven while any status bit is set. The decoder selects a mailbox on the read side, sees the frame at its head and pops it. Any accepted pop clears that mailbox's status bit. A frame that arrives at a mailbox with no free slot is lost, and this is recorded in a sticky per-mailbox overflow flag.

Top module: `mbox_hub`

## Requirements
- R1: After reset, `status`, `ovf` and `irq` are zero, `rx_ready` is 1, no mailbox is armed, and `rd_valid` is 0 for every value of `rd_sel`.
- R2: For a mailbox written with `cfg_mask_en`=0, a frame is accepted only when `rx_id` equals the stored identifier.
- R3: For a mailbox written with `cfg_mask_en`=1, a frame is accepted when `(rx_id & mask) == (id & mask)`.
- R4: When several armed mailboxes accept the same frame, only the lowest-numbered one stores it.
- R5: A frame that no armed mailbox accepts is stored nowhere.
- R6: `rd_id`/`rd_data` show the oldest stored frame of mailbox `rd_sel` while `rd_valid` is 1. A pop (`rd_req` with `rd_valid`=1) removes that frame, so frames leave in arrival order with identifier and payload intact.
- R7: On the clock edge that stores a frame and makes the mailbox's count exceed its configured size, bit `n` of `status` becomes 1 for mailbox `n`. A status bit that is already set does not re-arm from further frames.
- R8: `irq` is 1 exactly when at least one `status` bit is 1.
- R9: A pop of mailbox `n` clears `status[n]` on that edge. A later stored frame that leaves the count above the size sets it again.
- R10: Each mailbox holds 16 frames. A frame offered to a full mailbox that is not being popped is dropped, its stored contents are unchanged, and `ovf[n]` becomes 1 and stays 1.
- R11: A configuration write to mailbox `n` empties it and clears `status[n]` and `ovf[n]`. A write with `cfg_on`=0 leaves the mailbox accepting no frames.
- R12: `rx_ready` is 0 in any cycle with `cfg_we`=1, and a frame offered in that cycle is not stored.
- R13: A store and a pop on the same mailbox in one cycle both take effect: the count is unchanged, the new frame is queued behind the old ones, and the status bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Mailbox index written |
| cfg_on | input | 1 | 1 arms the mailbox, 0 disarms it |
| cfg_id | input | 11 | Identifier the mailbox accepts |
| cfg_mask | input | 11 | Bits of the identifier that take part in a masked compare |
| cfg_mask_en | input | 1 | 1 selects the masked compare, 0 the exact compare |
| cfg_size | input | 5 | Threshold count; status sets when the count exceeds it |
| rx_valid | input | 1 | Received frame offered |
| rx_ready | output | 1 | Frame taken on this edge when high together with rx_valid |
| rx_id | input | 11 | Received identifier |
| rx_data | input | 64 | Received payload, 8 bytes |
| rd_sel | input | 4 | Mailbox shown on the read side |
| rd_req | input | 1 | Pop the head frame of mailbox rd_sel |
| rd_valid | output | 1 | Mailbox rd_sel holds at least one frame |
| rd_id | output | 11 | Identifier of the head frame |
| rd_data | output | 64 | Payload of the head frame |
| status | output | 16 | Full flag per mailbox |
| ovf | output | 16 | Sticky overflow flag per mailbox |
| irq | output | 1 | Level interrupt, OR of status |

## Verification
A store from the receive side and a pop from the read side can both hit the same mailbox on one edge. This touches its count, both pointers and its status bit at once. The bench provokes this by setting `rx_valid` with an accepted identifier and `rd_req` on the same mailbox in one cycle, after the status bit has already been set. It then expects the status bit clear, the mailbox still holding one frame, and that frame being the newly arrived one. A configuration write in the same cycle as an offered frame is the second collision. It is judged by `rx_ready` falling and by the newly armed mailbox staying empty.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

   localparam int DEF_NUM_MBOX = 16;
   localparam int DEF_DEPTH    = 16;
   localparam int DEF_ID_W     = 11;
   localparam int DEF_DATA_W   = 64;

   // acceptance compare selected per mailbox
   typedef enum logic {
      MATCH_EXACT  = 1'b0,
      MATCH_MASKED = 1'b1
   } match_mode_e;

endpackage

// File: rtl/mbox_pick.sv
// Fixed-priority selector: the lowest set bit wins.
module mbox_pick #(
   parameter  int N  = 16,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  hit,
   output logic          any,
   output logic [IW-1:0] idx
);

   always_comb begin
      any = |hit;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hit[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/mbox_ram.sv
// Shared frame storage, one write port, asynchronous read port.
module mbox_ram #(
   parameter  int ENTRIES = 256,
   parameter  int W       = 75,
   localparam int AW      = $clog2(ENTRIES)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);

   logic [W-1:0] mem [ENTRIES];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/mbox_slot.sv
// One mailbox: filter registers, fill count, ring pointers and flags.
module mbox_slot
   import mbox_pkg::*;
#(
   parameter  int ID_W  = 11,
   parameter  int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_on,
   input  logic [ID_W-1:0]  cfg_id,
   input  logic [ID_W-1:0]  cfg_mask,
   input  match_mode_e      cfg_mode,
   input  logic [CNT_W-1:0] cfg_size,
   input  logic [ID_W-1:0]  rx_id,
   input  logic             grant,
   input  logic             pop_req,
   output logic             hit,
   output logic             store_en,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic             nonempty,
   output logic             status,
   output logic             ovf
);

   logic             armed_q;
   logic [ID_W-1:0]  id_q;
   logic [ID_W-1:0]  mask_q;
   match_mode_e      mode_q;
   logic [CNT_W-1:0] size_q;
   logic [CNT_W-1:0] count_q;
   logic             full;
   logic             pop;
   logic             drop;
   logic [CNT_W:0]   count_plus;

   always_comb begin
      if (!armed_q)                    hit = 1'b0;
      else if (mode_q == MATCH_MASKED) hit = (((rx_id ^ id_q) & mask_q) == '0);
      else                             hit = (rx_id == id_q);
   end

   assign full       = (count_q == CNT_W'(DEPTH));
   assign nonempty   = (count_q != '0);
   assign pop        = pop_req && nonempty;
   assign store_en   = grant && (!full || pop);
   assign drop       = grant && full && !pop;
   assign count_plus = {1'b0, count_q} + (CNT_W + 1)'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         id_q    <= '0;
         mask_q  <= '0;
         mode_q  <= MATCH_EXACT;
         size_q  <= '0;
         count_q <= '0;
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         status  <= 1'b0;
         ovf     <= 1'b0;
      end else if (cfg_we) begin
         armed_q <= cfg_on;
         id_q    <= cfg_id;
         mask_q  <= cfg_mask;
         mode_q  <= cfg_mode;
         size_q  <= cfg_size;
         count_q <= '0;
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         status  <= 1'b0;
         ovf     <= 1'b0;
      end else begin
         if (store_en) wr_ptr <= wr_ptr + 1'b1;
         if (pop)      rd_ptr <= rd_ptr + 1'b1;
         case ({store_en, pop})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
         if (pop)
            status <= 1'b0;
         else if (store_en && !status && (count_plus > {1'b0, size_q}))
            status <= 1'b1;
         if (drop) ovf <= 1'b1;
      end
   end

endmodule

// File: rtl/mbox_hub.sv
// Mailbox store: acceptance filtering, per-mailbox rings, full flags, interrupt.
module mbox_hub
   import mbox_pkg::*;
#(
   parameter  int NUM_MBOX = DEF_NUM_MBOX,
   parameter  int DEPTH    = DEF_DEPTH,
   parameter  int ID_W     = DEF_ID_W,
   parameter  int DATA_W   = DEF_DATA_W,
   localparam int SEL_W    = $clog2(NUM_MBOX),
   localparam int PTR_W    = $clog2(DEPTH),
   localparam int CNT_W    = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [SEL_W-1:0]    cfg_sel,
   input  logic                cfg_on,
   input  logic [ID_W-1:0]     cfg_id,
   input  logic [ID_W-1:0]     cfg_mask,
   input  logic                cfg_mask_en,
   input  logic [CNT_W-1:0]    cfg_size,
   input  logic                rx_valid,
   output logic                rx_ready,
   input  logic [ID_W-1:0]     rx_id,
   input  logic [DATA_W-1:0]   rx_data,
   input  logic [SEL_W-1:0]    rd_sel,
   input  logic                rd_req,
   output logic                rd_valid,
   output logic [ID_W-1:0]     rd_id,
   output logic [DATA_W-1:0]   rd_data,
   output logic [NUM_MBOX-1:0] status,
   output logic [NUM_MBOX-1:0] ovf,
   output logic                irq
);

   localparam int FR_W   = ID_W + DATA_W;
   localparam int ADDR_W = SEL_W + PTR_W;

   if (NUM_MBOX != (1 << SEL_W) || NUM_MBOX < 2) begin : g_bad_num
      $error("mbox_hub: NUM_MBOX must be a power of two, at least 2");
   end
   if (DEPTH != (1 << PTR_W) || DEPTH < 2) begin : g_bad_depth
      $error("mbox_hub: DEPTH must be a power of two, at least 2");
   end
   if (ID_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("mbox_hub: identifier and payload widths must be positive");
   end

   logic [NUM_MBOX-1:0] hit;
   logic [NUM_MBOX-1:0] store_en;
   logic [NUM_MBOX-1:0] nonempty;
   logic [PTR_W-1:0]    wptr_a [NUM_MBOX];
   logic [PTR_W-1:0]    rptr_a [NUM_MBOX];
   logic                any_hit;
   logic [SEL_W-1:0]    win;
   logic                accept;
   match_mode_e         mode_in;
   logic [FR_W-1:0]     rd_frame;

   // a configuration write owns the cycle; frames wait
   assign rx_ready = !cfg_we;
   assign accept   = rx_valid && rx_ready;
   assign mode_in  = cfg_mask_en ? MATCH_MASKED : MATCH_EXACT;

   mbox_pick #(.N(NUM_MBOX)) u_pick (
      .hit (hit),
      .any (any_hit),
      .idx (win)
   );

   for (genvar g = 0; g < NUM_MBOX; g++) begin : g_slot
      mbox_slot #(.ID_W(ID_W), .DEPTH(DEPTH)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_we   (cfg_we && (cfg_sel == SEL_W'(g))),
         .cfg_on   (cfg_on),
         .cfg_id   (cfg_id),
         .cfg_mask (cfg_mask),
         .cfg_mode (mode_in),
         .cfg_size (cfg_size),
         .rx_id    (rx_id),
         .grant    (accept && any_hit && (win == SEL_W'(g))),
         .pop_req  (rd_req && (rd_sel == SEL_W'(g))),
         .hit      (hit[g]),
         .store_en (store_en[g]),
         .wr_ptr   (wptr_a[g]),
         .rd_ptr   (rptr_a[g]),
         .nonempty (nonempty[g]),
         .status   (status[g]),
         .ovf      (ovf[g])
      );
   end

   mbox_ram #(.ENTRIES(NUM_MBOX * DEPTH), .W(FR_W)) u_ram (
      .clk   (clk),
      .we    (|store_en),
      .waddr (ADDR_W'({win, wptr_a[win]})),
      .wdata ({rx_id, rx_data}),
      .raddr (ADDR_W'({rd_sel, rptr_a[rd_sel]})),
      .rdata (rd_frame)
   );

   assign rd_valid          = nonempty[rd_sel];
   assign {rd_id, rd_data}  = rd_frame;
   assign irq               = |status;

endmodule

// File: rtl/mbox_hub_chk.sv
// Temporal checks for mbox_hub, attached by bind.
module mbox_hub_chk #(
   parameter  int NUM_MBOX = 16,
   localparam int SEL_W    = $clog2(NUM_MBOX)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cfg_we,
   input logic [SEL_W-1:0]    cfg_sel,
   input logic                rx_valid,
   input logic                rx_ready,
   input logic [SEL_W-1:0]    rd_sel,
   input logic                rd_req,
   input logic                rd_valid,
   input logic [NUM_MBOX-1:0] status,
   input logic [NUM_MBOX-1:0] ovf,
   input logic                irq
);

   // R7: a status bit can only rise after a frame was taken
   p_set_needs_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((status & ~$past(status)) != '0) |-> $past(rx_valid && rx_ready));

   // R8: the interrupt only drops after a pop or a configuration write
   p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(rd_req || cfg_we));

   // R9: an accepted pop leaves the popped mailbox's status bit clear
   p_pop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_valid && !cfg_we) |=> !status[$past(rd_sel)]);

   // R10: overflow flags never fall without a configuration write
   p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> ((ovf & $past(ovf)) == $past(ovf)));

   // R11: a configuration write clears both flags of its mailbox
   p_reconf_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (!status[$past(cfg_sel)] && !ovf[$past(cfg_sel)]));

endmodule

bind mbox_hub mbox_hub_chk #(.NUM_MBOX(NUM_MBOX)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_we   (cfg_we),
   .cfg_sel  (cfg_sel),
   .rx_valid (rx_valid),
   .rx_ready (rx_ready),
   .rd_sel   (rd_sel),
   .rd_req   (rd_req),
   .rd_valid (rd_valid),
   .status   (status),
   .ovf      (ovf),
   .irq      (irq)
);

// File: tb/sim_mbox_hub.sv
`timescale 1ns/1ps
module sim_mbox_hub;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_sel = '0;
   logic        cfg_on = 1'b0;
   logic [10:0] cfg_id = '0;
   logic [10:0] cfg_mask = '0;
   logic        cfg_mask_en = 1'b0;
   logic [4:0]  cfg_size = '0;
   logic        rx_valid = 1'b0;
   logic        rx_ready;
   logic [10:0] rx_id = '0;
   logic [63:0] rx_data = '0;
   logic [3:0]  rd_sel = '0;
   logic        rd_req = 1'b0;
   logic        rd_valid;
   logic [10:0] rd_id;
   logic [63:0] rd_data;
   logic [15:0] status;
   logic [15:0] ovf;
   logic        irq;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   mbox_hub u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_on(cfg_on),
      .cfg_id(cfg_id), .cfg_mask(cfg_mask), .cfg_mask_en(cfg_mask_en), .cfg_size(cfg_size),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_id(rx_id), .rx_data(rx_data),
      .rd_sel(rd_sel), .rd_req(rd_req), .rd_valid(rd_valid), .rd_id(rd_id),
      .rd_data(rd_data), .status(status), .ovf(ovf), .irq(irq)
   );

   // routing vectors: {expected mailbox (16 = dropped), identifier}
   localparam logic [15:0] VEC [10] = '{
      {5'd0,  11'h100}, {5'd16, 11'h101}, {5'd1,  11'h125}, {5'd1,  11'h123},
      {5'd1,  11'h12F}, {5'd16, 11'h130}, {5'd3,  11'h2AB}, {5'd5,  11'h7FF},
      {5'd16, 11'h300}, {5'd16, 11'h000}
   };

   function automatic logic [63:0] tagdata(input int t);
      return {16'hC0DE, 16'(t), 32'h1234_5678 ^ 32'(t)};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cfg_wr(input int sel, input bit on, input logic [10:0] id,
                         input logic [10:0] mask, input bit men, input int size);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_on = on; cfg_id = id;
      cfg_mask = mask; cfg_mask_en = men; cfg_size = 5'(size);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic send(input logic [10:0] id, input int tag);
      @(negedge clk);
      rx_valid = 1'b1; rx_id = id; rx_data = tagdata(tag);
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic occ(output logic [15:0] m);
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         rd_sel = 4'(i);
         #1 m[i] = rd_valid;
      end
   endtask

   task automatic pop_chk(input int sel, input logic [10:0] id, input int tag, input string req);
      @(negedge clk);
      rd_sel = 4'(sel);
      #1;
      chk({req, " head valid"}, 64'(rd_valid), 64'd1);
      chk({req, " head id"}, 64'(rd_id), 64'(id));
      chk({req, " head data"}, rd_data, tagdata(tag));
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      logic [15:0] m;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      #1;
      chk("R1 status", 64'(status), 64'd0);
      chk("R1 irq", 64'(irq), 64'd0);
      chk("R1 ovf", 64'(ovf), 64'd0);
      chk("R1 rx_ready", 64'(rx_ready), 64'd1);
      occ(m);
      chk("R1 occupancy", 64'(m), 64'd0);

      // filter setup for the routing table
      cfg_wr(0, 1, 11'h100, 11'h000, 0, 15);
      cfg_wr(1, 1, 11'h120, 11'h7F0, 1, 15);
      cfg_wr(2, 1, 11'h123, 11'h000, 0, 15);
      cfg_wr(3, 1, 11'h200, 11'h700, 1, 15);
      cfg_wr(4, 0, 11'h300, 11'h000, 0, 15);
      cfg_wr(5, 1, 11'h7FF, 11'h000, 0, 15);

      // R2 R3 R4 R5: routing table walk
      for (int v = 0; v < 10; v++) begin
         logic [10:0] id;
         int          exp;
         id  = VEC[v][10:0];
         exp = int'(VEC[v][15:11]);
         send(id, 100 + v);
         occ(m);
         chk($sformatf("R2 R3 R4 R5 route vec %0d", v), 64'(m),
             (exp == 16) ? 64'd0 : (64'd1 << exp));
         if (exp != 16) pop_chk(exp, id, 100 + v, $sformatf("R6 route vec %0d", v));
      end

      // R7 R8 R9 R6: threshold, interrupt, clear by pop, re-arm, order
      cfg_wr(6, 1, 11'h050, 11'h000, 0, 2);
      send(11'h050, 1);
      send(11'h050, 2);
      chk("R7 below threshold", 64'(status), 64'd0);
      chk("R8 irq low", 64'(irq), 64'd0);
      send(11'h050, 3);
      chk("R7 status set", 64'(status), 64'h0040);
      chk("R8 irq high", 64'(irq), 64'd1);
      send(11'h050, 4);
      chk("R7 status held", 64'(status), 64'h0040);
      pop_chk(6, 11'h050, 1, "R6 order 1");
      chk("R9 pop clears", 64'(status), 64'd0);
      chk("R8 irq follows", 64'(irq), 64'd0);
      send(11'h050, 5);
      chk("R9 re-arm", 64'(status), 64'h0040);
      pop_chk(6, 11'h050, 2, "R6 order 2");
      pop_chk(6, 11'h050, 3, "R6 order 3");
      pop_chk(6, 11'h050, 4, "R6 order 4");
      pop_chk(6, 11'h050, 5, "R6 order 5");

      // R11: reconfigure a mailbox that holds frames
      send(11'h050, 7);
      send(11'h050, 8);
      send(11'h050, 9);
      chk("R11 pre status", 64'(status), 64'h0040);
      cfg_wr(6, 1, 11'h050, 11'h000, 0, 2);
      chk("R11 status cleared", 64'(status), 64'd0);
      @(negedge clk); rd_sel = 4'd6; #1;
      chk("R11 emptied", 64'(rd_valid), 64'd0);

      // R10: full store, overflow flag, contents intact
      cfg_wr(7, 1, 11'h060, 11'h000, 0, 15);
      for (int k = 0; k < 16; k++) send(11'h060, k);
      chk("R10 status at 16", 64'(status), 64'h0080);
      chk("R10 no ovf yet", 64'(ovf), 64'd0);
      send(11'h060, 8'hDE);
      chk("R10 ovf set", 64'(ovf), 64'h0080);
      for (int k = 0; k < 16; k++) pop_chk(7, 11'h060, k, "R10 drain");
      @(negedge clk); rd_sel = 4'd7; #1;
      chk("R10 dropped frame absent", 64'(rd_valid), 64'd0);
      chk("R10 ovf sticky", 64'(ovf), 64'h0080);
      cfg_wr(7, 1, 11'h060, 11'h000, 0, 15);
      chk("R11 ovf cleared", 64'(ovf), 64'd0);

      // R11: disarmed mailbox accepts nothing
      cfg_wr(0, 0, 11'h100, 11'h000, 0, 15);
      send(11'h100, 20);
      occ(m);
      chk("R11 disarmed", 64'(m), 64'd0);

      // R12: configuration write stalls a frame in the same cycle
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 4'd9; cfg_on = 1'b1; cfg_id = 11'h090;
      cfg_mask = '0; cfg_mask_en = 1'b0; cfg_size = 5'd15;
      rx_valid = 1'b1; rx_id = 11'h090; rx_data = tagdata(30);
      #1;
      chk("R12 ready low", 64'(rx_ready), 64'd0);
      @(negedge clk);
      cfg_we = 1'b0; rx_valid = 1'b0;
      occ(m);
      chk("R12 frame not taken", 64'(m), 64'd0);
      #1;
      chk("R12 ready back", 64'(rx_ready), 64'd1);
      send(11'h090, 31);
      pop_chk(9, 11'h090, 31, "R12 later frame");

      // R13: store and pop on one mailbox in one cycle
      cfg_wr(8, 1, 11'h070, 11'h000, 0, 0);
      send(11'h070, 1);
      chk("R13 pre status", 64'(status), 64'h0100);
      @(negedge clk);
      rx_valid = 1'b1; rx_id = 11'h070; rx_data = tagdata(2);
      rd_sel = 4'd8; rd_req = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0; rd_req = 1'b0;
      chk("R13 status cleared", 64'(status), 64'd0);
      chk("R13 irq low", 64'(irq), 64'd0);
      pop_chk(8, 11'h070, 2, "R13 new frame kept");
      @(negedge clk); rd_sel = 4'd8; #1;
      chk("R13 count unchanged", 64'(rd_valid), 64'd0);

      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule